// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block collects up to 32 interrupt request lines into one interrupt line toward a processor. Each request line sets a bit in a status register. Which lines act on a rising edge and which act on a high level is chosen by a build-time parameter. An enable register masks the status register to form the pending register. A vector register gives the number of the lowest pending line, so a handler can branch at once without scanning bits. Software works through a word-addressed register port. Writing the acknowledge word clears status bits. Two alias words set or clear enable bits without a read-modify-write.

A two-bit control word governs the block as a whole. One bit lets the combined interrupt reach the output. The other bit decides who owns the status register. When that bit is set, hardware capture from the input lines fills status, and software writes to status are dropped. When it is clear, the input lines are not captured and software may write status directly, which can raise interrupts from software. All inputs are taken to be synchronous to the block clock.

Top module: `irq_ctrl_top`

## Requirements
- R1: The word offset on `reg_addr` selects a register: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 control. A write takes effect at the clock edge that samples it. Read data appears on `reg_rdata` one cycle after the read and shows the register contents as they were before that edge's update.
- R2: A write to offset 3 clears every status bit that is 1 in the written value. No other status bit changes.
- R3: A write to offset 4 ORs the value into enable. A write to offset 5 clears the enable bits that are 1 in the value. Neither write changes any other enable bit. A write to offset 2 loads enable directly.
- R4: The control word stores only bits [1:0] of a write. Reading it returns those two bits, with zeros above them.
- R5: While control bit 1 is set, writes to offset 0 are ignored. While it is clear, a write to offset 0 loads status with the written value.
- R6: An input whose bit in `EDGE_MASK` is 1 is edge-sensitive. When it goes from 0 to 1 while control bit 1 is set, its status bit is set once. Holding the input high does not set the bit again after an acknowledge.
- R7: An input whose bit in `EDGE_MASK` is 0 is level-sensitive. Its status bit is set in each cycle that the input is high while control bit 1 is set. While control bit 1 is clear, no input, of either kind, changes status.
- R8: Pending, read at offset 1, always equals status AND enable.
- R9: The vector register at offset 6 holds the index of the lowest-numbered set pending bit, or 0xFFFFFFFF when no bit is pending. It follows pending in the same cycle that pending changes.
- R10: `irq_out` is 1 exactly when control bit 0 is set and at least one pending bit is set. It updates at the same edge as the write or capture that causes the change.
- R11: Writes to offsets 1 and 6 have no effect. Reads of offsets 3, 4 and 5, and of any offset from 8 upward, return zero.
- R12: After reset, status, enable, pending and control read zero, the vector reads 0xFFFFFFFF, and `irq_out` is 0.
- R13: Acknowledging a level-sensitive input that is still high and still captured clears its status bit at that edge. Capture sets the bit again at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_in | input | 32 | Interrupt request lines |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
Software-written status values with one, two and widely spaced bits set are run through the vector. They show that the lowest index wins whether the competing bit lies above it, at bit 0 or at bit 31, and that an empty pending set reads all ones. Level and edge inputs are each held high across an acknowledge. The level input must reappear one cycle after the acknowledge, while the edge input must stay clear until a fresh rising edge. The same inputs are then pulsed with capture turned off, which shows that capture is gated separately from the output gate. Writes to status with capture on and with capture off, together with writes to the read-only words, show which writes take effect and which are dropped.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned OFS_STATUS  = 0;
  localparam int unsigned OFS_PENDING = 1;
  localparam int unsigned OFS_ENABLE  = 2;
  localparam int unsigned OFS_ACK     = 3;
  localparam int unsigned OFS_SET_EN  = 4;
  localparam int unsigned OFS_CLR_EN  = 5;
  localparam int unsigned OFS_VECTOR  = 6;
  localparam int unsigned OFS_CTRL    = 7;

  localparam int unsigned CTRL_W       = 2;
  localparam int unsigned CTRL_OUT_BIT = 0;
  localparam int unsigned CTRL_CAP_BIT = 1;

  typedef struct packed {
    logic status;
    logic enable;
    logic ack;
    logic set_en;
    logic clr_en;
    logic ctrl;
  } wr_sel_t;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_en,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_SRC-1:0] cap_req
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= irq_in;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      assign cap_req[i] = cap_en & irq_in[i] & ~prev_q[i];
    end else begin : g_level
      assign cap_req[i] = cap_en & irq_in[i];
    end
  end

  // An edge input must be low on the previous sample to request capture
  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
    ((cap_req & EDGE_MASK) & prev_q) == '0); // R6
  AST_NO_CAP_OFF: assert property (@(posedge clk) disable iff (rst)
    !cap_en |-> cap_req == '0); // R7
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  wr_sel_t            wsel,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [CTRL_W-1:0]  wctrl,
  input  logic [NUM_SRC-1:0] cap_req,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] enable_q,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [NUM_SRC-1:0] status_d,
  output logic [NUM_SRC-1:0] enable_d,
  output logic [CTRL_W-1:0]  ctrl_d
);
  logic [NUM_SRC-1:0] ack_mask;
  logic [NUM_SRC-1:0] status_base;

  always_comb begin
    ack_mask    = wsel.ack ? wdata : '0;
    status_base = status_q;
    if (wsel.status && !ctrl_q[CTRL_CAP_BIT]) status_base = wdata;
    // acknowledge wins over a capture in the same cycle
    status_d = (status_base | cap_req) & ~ack_mask;
  end

  always_comb begin
    enable_d = enable_q;
    if (wsel.enable) enable_d = wdata;
    if (wsel.set_en) enable_d = enable_d | wdata;
    if (wsel.clr_en) enable_d = enable_d & ~wdata;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wsel.ctrl) ctrl_d = wctrl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      ctrl_q   <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      ctrl_q   <= ctrl_d;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wsel.ack |=> (status_q & $past(wdata)) == '0); // R2
  AST_SET_EN: assert property (@(posedge clk) disable iff (rst)
    wsel.set_en && !wsel.clr_en |=> (enable_q & $past(wdata)) == $past(wdata)); // R3
  AST_CLR_EN: assert property (@(posedge clk) disable iff (rst)
    wsel.clr_en |=> (enable_q & $past(wdata)) == '0); // R3
  AST_STATUS_LOCK: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTRL_CAP_BIT] && !wsel.ack |=> (status_q & $past(status_q)) == $past(status_q)); // R5
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  vec
);
  logic             any;
  logic [IDX_W-1:0] idx;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
    vec = any ? DATA_W'(idx) : '1;
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_out
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  wr_sel_t            wsel;
  logic [NUM_SRC-1:0] cap_req;
  logic [NUM_SRC-1:0] status_q, enable_q, status_d, enable_d;
  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [DATA_W-1:0]  vec_d, vec_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               irq_q;

  always_comb begin
    wsel.status = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
    wsel.enable = reg_wr && (reg_addr == ADDR_W'(OFS_ENABLE));
    wsel.ack    = reg_wr && (reg_addr == ADDR_W'(OFS_ACK));
    wsel.set_en = reg_wr && (reg_addr == ADDR_W'(OFS_SET_EN));
    wsel.clr_en = reg_wr && (reg_addr == ADDR_W'(OFS_CLR_EN));
    wsel.ctrl   = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  end

  irq_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk(clk), .rst(rst), .cap_en(ctrl_q[CTRL_CAP_BIT]),
    .irq_in(irq_in), .cap_req(cap_req)
  );

  irq_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .wsel(wsel),
    .wdata(reg_wdata[NUM_SRC-1:0]), .wctrl(reg_wdata[CTRL_W-1:0]),
    .cap_req(cap_req),
    .status_q(status_q), .enable_q(enable_q), .ctrl_q(ctrl_q),
    .status_d(status_d), .enable_d(enable_d), .ctrl_d(ctrl_d)
  );

  assign pend_q = status_q & enable_q;
  assign pend_d = status_d & enable_d;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_enc (
    .pend(pend_d), .vec(vec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '1;
      irq_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      irq_q <= ctrl_d[CTRL_OUT_BIT] && (pend_d != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_W'(OFS_STATUS):  rdata_q <= DATA_W'(status_q);
        ADDR_W'(OFS_PENDING): rdata_q <= DATA_W'(pend_q);
        ADDR_W'(OFS_ENABLE):  rdata_q <= DATA_W'(enable_q);
        ADDR_W'(OFS_VECTOR):  rdata_q <= vec_q;
        ADDR_W'(OFS_CTRL):    rdata_q <= DATA_W'(ctrl_q);
        default:              rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = irq_q;

  AST_VEC_HIT: assert property (@(posedge clk) disable iff (rst)
    (vec_q != '1) |-> pend_q[vec_q[IDX_W-1:0]]); // R9
  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (vec_q == '1) |-> (pend_q == '0)); // R9
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_q == (ctrl_q[CTRL_OUT_BIT] && (pend_q != '0))); // R10
endmodule

// File: tb/tb_irq_ctrl_top.sv
module tb_irq_ctrl_top;
  localparam logic [31:0] EMASK = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] irq_in = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_ctrl_top #(.NUM_SRC(32), .DATA_W(32), .ADDR_W(4), .EDGE_MASK(EMASK)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // monitor: compare each read result one cycle after its strobe
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s: actual=%08h expected=%08h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string t);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", t, irq_out, e);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset values
    rd_chk(4'd0, 32'h0, "R12 status");
    rd_chk(4'd2, 32'h0, "R12 enable");
    rd_chk(4'd1, 32'h0, "R12 pending");
    rd_chk(4'd7, 32'h0, "R12 control");
    rd_chk(4'd6, 32'hFFFF_FFFF, "R12 vector");
    irq_chk(1'b0, "R12 irq_out");
    // R5 software status write with capture off, R1 map
    wr_reg(4'd0, 32'h0000_0014);
    rd_chk(4'd0, 32'h0000_0014, "R5 R1 status write");
    rd_chk(4'd1, 32'h0, "R8 pending with enable 0");
    rd_chk(4'd6, 32'hFFFF_FFFF, "R9 empty vector");
    wr_reg(4'd4, 32'h0000_0010);
    rd_chk(4'd2, 32'h0000_0010, "R3 set enable");
    rd_chk(4'd1, 32'h0000_0010, "R8 pending");
    rd_chk(4'd6, 32'd4, "R9 vector 4");
    irq_chk(1'b0, "R10 output gate off");
    wr_reg(4'd7, 32'h1);
    irq_chk(1'b1, "R10 output gate on");
    wr_reg(4'd4, 32'h0000_0004);
    rd_chk(4'd2, 32'h0000_0014, "R3 set keeps others");
    rd_chk(4'd6, 32'd2, "R9 lowest wins");
    wr_reg(4'd5, 32'h0000_0004);
    rd_chk(4'd2, 32'h0000_0010, "R3 clear keeps others");
    rd_chk(4'd6, 32'd4, "R9 vector back to 4");
    // R2 acknowledge
    wr_reg(4'd3, 32'h0000_0010);
    irq_chk(1'b0, "R10 drops after ack");
    rd_chk(4'd0, 32'h0000_0004, "R2 ack clears one bit");
    rd_chk(4'd6, 32'hFFFF_FFFF, "R9 nothing pending");
    // R4 control width, R5 status locked
    wr_reg(4'd7, 32'hFFFF_FFFF);
    rd_chk(4'd7, 32'h3, "R4 control low bits");
    wr_reg(4'd0, 32'h0000_00FF);
    rd_chk(4'd0, 32'h0000_0004, "R5 status write ignored");
    // R7 level input, R13 re-set after ack
    irq_in[3] = 1'b1;
    @(negedge clk);
    rd_chk(4'd0, 32'h0000_000C, "R7 level captured");
    wr_reg(4'd3, 32'h0000_0008);
    rd_chk(4'd0, 32'h0000_0004, "R13 cleared at ack edge");
    rd_chk(4'd0, 32'h0000_000C, "R13 re-set next cycle");
    irq_in[3] = 1'b0;
    wr_reg(4'd3, 32'h0000_0008);
    rd_chk(4'd0, 32'h0000_0004, "R7 level cleared when low");
    // R6 edge input
    irq_in[20] = 1'b1;
    @(negedge clk);
    rd_chk(4'd0, 32'h0010_0004, "R6 edge captured");
    wr_reg(4'd3, 32'h0010_0000);
    rd_chk(4'd0, 32'h0000_0004, "R6 ack while high");
    rd_chk(4'd0, 32'h0000_0004, "R6 no re-set while high");
    irq_in[20] = 1'b0;
    @(negedge clk);
    irq_in[20] = 1'b1;
    @(negedge clk);
    rd_chk(4'd0, 32'h0010_0004, "R6 new edge captured");
    irq_in[20] = 1'b0;
    // R7 capture off blocks both kinds
    wr_reg(4'd7, 32'h1);
    irq_in[21] = 1'b1;
    irq_in[5]  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_chk(4'd0, 32'h0010_0004, "R7 no capture when off");
    irq_in[21] = 1'b0;
    irq_in[5]  = 1'b0;
    // R9 priority at the extremes
    wr_reg(4'd0, 32'h8000_0000);
    wr_reg(4'd4, 32'hFFFF_FFFF);
    rd_chk(4'd1, 32'h8000_0000, "R8 pending all enabled");
    rd_chk(4'd6, 32'd31, "R9 vector 31");
    irq_chk(1'b1, "R10 bit 31 pending");
    wr_reg(4'd0, 32'h8000_0001);
    rd_chk(4'd6, 32'd0, "R9 vector 0");
    // R11 read-only and unused offsets
    wr_reg(4'd1, 32'h0000_FFFF);
    wr_reg(4'd6, 32'd5);
    rd_chk(4'd1, 32'h8000_0001, "R11 pending write ignored");
    rd_chk(4'd6, 32'd0, "R11 vector write ignored");
    rd_chk(4'd9, 32'h0, "R11 unused offset");
    rd_chk(4'd3, 32'h0, "R11 ack reads zero");
    rd_chk(4'd4, 32'h0, "R11 set alias reads zero");
    rd_chk(4'd5, 32'h0, "R11 clear alias reads zero");
    // R10 gate off with pending
    wr_reg(4'd7, 32'h0);
    irq_chk(1'b0, "R10 gate off while pending");
    wr_reg(4'd2, 32'h0000_0000);
    rd_chk(4'd1, 32'h0, "R3 direct enable write");
    rd_chk(4'd6, 32'hFFFF_FFFF, "R9 empty after disable");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule